// File: doc/BRIEF.md
# Enable-Driven One-Second Prescaler

This block divides a stream of single-cycle enable strobes down to a once-per-second event. The block and everything around it run on one fast system clock. A companion circuit raises the strobe input for exactly one system clock at a 32.768 kHz rate. The prescaler counts those strobes modulo a parameterised ratio, which defaults to 32768. From the single count it produces two outputs: a pulse one system clock wide once per division cycle, and a square wave with an exact 50% duty cycle at the divided rate.

Downstream logic uses the pulse as a clock enable for slow timekeeping, such as seconds counters. The square wave suits a visible blink or a low-rate reference. An active-low synchronous reset and a separate active-low synchronous clear both return the count to zero. The block has no data path, so every pin is a plain control or status signal and none uses a valid/ready handshake.

Top module: `sec_prescaler`

## Requirements
- R1: The count advances by one only at a clock edge where `strobe_i` is high and neither reset nor clear is asserted. When `strobe_i` is low the count holds, and the outputs show no change attributable to that cycle.
- R2: `tick_o` is high during a cycle in which `strobe_i` is high while the count holds `DIV_RATIO-1`, with reset and clear deasserted. The count wraps to 0 at the following edge. `tick_o` is low in every other cycle. `tick_o` is combinational from the strobe.
- R3: `tick_o` is never high in two consecutive cycles.
- R4: `square_o` is low while the count is in 0 to `DIV_RATIO/2-1` and high while it is in `DIV_RATIO/2` to `DIV_RATIO-1`. `DIV_RATIO` must be even and at least 2.
- R5: With `rst_n_i` low at a clock edge, the count becomes 0. While `rst_n_i` is low, both outputs are low.
- R6: With `clr_n_i` low and `rst_n_i` high at a clock edge, the count becomes 0. While `clr_n_i` is low, both outputs are low.
- R7: Reset takes priority over clear, and clear takes priority over counting. A strobe in a reset or clear cycle is not counted.
- R8: With reset and clear held high, consecutive ticks are exactly `DIV_RATIO` strobes apart. `square_o` changes level once every `DIV_RATIO/2` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| clr_n_i | input | 1 | Synchronous count clear, active low |
| strobe_i | input | 1 | One-cycle count enable |
| tick_o | output | 1 | One-cycle pulse per division cycle |
| square_o | output | 1 | 50% duty square wave at the divided rate |

## Verification
On every clock the assertions check four things:
- the count holds when the strobe is low;
- reset and clear zero the count;
- a tick appears only at the terminal count with a strobe present, and never two cycles running;
- the square wave rises only at the half-way count.

Only the bench scenarios can show the exact spacing of ticks and square-wave edges over full division cycles. The same holds for the priority among reset, clear and strobe when they coincide near the wrap point, and for the output levels throughout long random strobe patterns.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;
  // Width of a counter holding 0 .. ratio-1, never less than one bit
  function automatic int unsigned count_width(input int unsigned ratio);
    int unsigned w;
    w = 1;
    while ((32'd1 << w) < ratio) w++;
    return w;
  endfunction

  typedef enum logic [1:0] {
    CTL_RESET = 2'd0,
    CTL_CLEAR = 2'd1,
    CTL_HOLD  = 2'd2,
    CTL_STEP  = 2'd3
  } ctl_e;
endpackage

// File: rtl/prescale_ctl.sv
module prescale_ctl
  import sec_prescaler_pkg::*;
(
  input  logic rst_n_i,
  input  logic clr_n_i,
  input  logic strobe_i,
  output ctl_e ctl_o,
  output logic active_o
);
  // Priority: reset, then clear, then strobe
  always_comb begin
    if (!rst_n_i)      ctl_o = CTL_RESET;
    else if (!clr_n_i) ctl_o = CTL_CLEAR;
    else if (strobe_i) ctl_o = CTL_STEP;
    else               ctl_o = CTL_HOLD;
  end

  assign active_o = rst_n_i && clr_n_i;
endmodule

// File: rtl/prescale_counter.sv
module prescale_counter
  import sec_prescaler_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 32768,
  localparam int unsigned CNT_W = count_width(DIV_RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  ctl_e             ctl_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  assign at_last_o = (count_o == LAST);

  always_ff @(posedge clk_i) begin
    unique case (ctl_i)
      CTL_RESET, CTL_CLEAR: count_o <= '0;
      CTL_STEP:  count_o <= at_last_o ? '0 : count_o + 1'b1;
      default:   count_o <= count_o;
    endcase
  end

  // R5
  reset_zero_chk: assert property (@(posedge clk_i)
    (ctl_i == CTL_RESET) |=> (count_o == '0));

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ctl_i == CTL_CLEAR) |=> (count_o == '0));

  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ctl_i == CTL_HOLD) |=> $stable(count_o));

  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ctl_i == CTL_STEP && at_last_o) |=> (count_o == '0));
endmodule

// File: rtl/prescale_decode.sv
module prescale_decode
  import sec_prescaler_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 32768,
  localparam int unsigned CNT_W = count_width(DIV_RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             active_i,
  input  logic             strobe_i,
  input  logic             at_last_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             tick_o,
  output logic             square_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DIV_RATIO / 2);

  assign tick_o   = active_i && strobe_i && at_last_i;
  assign square_o = active_i && (count_i >= HALF);

  // R3
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_o |=> !tick_o);

  // R4
  square_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(square_o) |-> (count_i == HALF));
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
  import sec_prescaler_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 32768
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_n_i,
  input  logic strobe_i,
  output logic tick_o,
  output logic square_o
);
  localparam int unsigned CNT_W = count_width(DIV_RATIO);

  // R4
  initial ratio_even_chk: assert (DIV_RATIO >= 2 && DIV_RATIO % 2 == 0);

  ctl_e             ctl;
  logic             active;
  logic [CNT_W-1:0] count;
  logic             at_last;

  prescale_ctl ctl_i (
    .rst_n_i  (rst_n_i),
    .clr_n_i  (clr_n_i),
    .strobe_i (strobe_i),
    .ctl_o    (ctl),
    .active_o (active)
  );

  prescale_counter #(.DIV_RATIO(DIV_RATIO)) cnt_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .ctl_i     (ctl),
    .count_o   (count),
    .at_last_o (at_last)
  );

  prescale_decode #(.DIV_RATIO(DIV_RATIO)) dec_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .active_i  (active),
    .strobe_i  (strobe_i),
    .at_last_i (at_last),
    .count_i   (count),
    .tick_o    (tick_o),
    .square_o  (square_o)
  );

  // R7
  tick_gated_chk: assert property (@(posedge clk_i)
    (!rst_n_i || !clr_n_i) |-> (!tick_o && !square_o));
endmodule

// File: tb/sec_prescaler_tb_top.sv
module sec_prescaler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 32768;
  localparam int HALF       = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, strobe = 1'b0;
  logic tick, square;

  int checks = 0, errors = 0;
  int model_cnt = 0;
  int strobes_since_tick = -1;
  int strobes_since_sq = -1;
  logic prev_tick = 1'b0, prev_sq = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_prescaler #(.DIV_RATIO(DIV)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .clr_n_i(clr_n), .strobe_i(strobe),
    .tick_o(tick), .square_o(square)
  );

  function automatic logic exp_tick(input int cnt, input logic r, input logic c, input logic s);
    return r && c && s && (cnt == DIV - 1);
  endfunction

  function automatic logic exp_square(input int cnt, input logic r, input logic c);
    return r && c && (cnt >= HALF);
  endfunction

  function automatic int next_cnt(input int cnt, input logic r, input logic c, input logic s);
    if (!r || !c) return 0;
    if (s) return (cnt + 1) % DIV;
    return cnt;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // One cycle: inputs applied just after a rising edge, outputs checked on the falling edge
  task automatic cycle(input logic r, input logic c, input logic s);
    string req;
    rst_n = r; clr_n = c; strobe = s;
    @(negedge clk);
    if (!r && !c) req = "R7";
    else if (!r) req = "R5";
    else if (!c) req = "R6";
    else if (!s) req = "R1";
    else req = "R2";
    check(req, tick, exp_tick(model_cnt, r, c, s), "tick");
    check((r && c) ? "R4" : req, square, exp_square(model_cnt, r, c), "square");
    if (prev_tick && tick) check("R3", 1'b1, 1'b0, "tick two cycles running");
    if (r && c) begin
      // R8 spacing of ticks and square-wave edges in strobes
      if (tick) begin
        if (strobes_since_tick >= 0) check_int("R8", strobes_since_tick + 1, DIV, "strobes per tick");
        strobes_since_tick = 0;
      end else if (s && strobes_since_tick >= 0) strobes_since_tick++;
      if (square != prev_sq) begin
        if (strobes_since_sq >= 0) check_int("R8", strobes_since_sq, HALF, "strobes per half period");
        strobes_since_sq = 0;
      end
      if (s && strobes_since_sq >= 0) strobes_since_sq++;
    end else begin
      strobes_since_tick = -1;
      strobes_since_sq = 0;
    end
    prev_tick = tick;
    prev_sq = square;
    @(posedge clk);
    model_cnt = next_cnt(model_cnt, r, c, s);
    #1;
  endtask

  task automatic run_to(input int target, input logic s_dense);
    while (model_cnt != target) cycle(1'b1, 1'b1, s_dense);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    @(posedge clk); #1;
    // Reset state
    repeat (3) cycle(1'b0, 1'b1, 1'b1);
    // R1: strobe low holds
    repeat (5) cycle(1'b1, 1'b1, 1'b0);
    // Dense strobes through a full period and a wrap
    run_to(DIV - 1, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);          // R1 at terminal count: no tick
    cycle(1'b1, 1'b1, 1'b1);          // R2 tick and wrap
    cycle(1'b1, 1'b1, 1'b1);          // R3 no repeat
    // R6: clear at terminal count with strobe
    run_to(DIV - 1, 1'b1);
    cycle(1'b1, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    // R7: reset and clear together in the upper half
    run_to(HALF + 3, 1'b1);
    cycle(1'b0, 1'b0, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    // R4 boundary around the half-way point
    run_to(HALF - 1, 1'b1);
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b1);
    // Random strobe density with rare clear and reset
    for (int i = 0; i < 90000; i++) begin
      logic s, c, r;
      s = (($urandom % 8) != 0);
      c = (($urandom % 30000) != 0);
      r = (($urandom % 45000) != 0);
      cycle(r, c, s);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule